// File: doc/BRIEF.md
# Three-Modulus Residue-to-Binary Converter

This block rebuilds a binary integer from its residues for the modulus set {2^(2n), 2^n−1, 2^(n+1)−1}, where n is a parameter of at least 2. It takes three residues and returns the single integer in the range [0, M) that has them, where M is the product of the three moduli. The conversion uses mixed-radix digits. The first digit is the low residue itself. The second and third digits are formed by end-around-carry carry-save adders and modulo 2^k−1 adders, with no lookup table.

The two odd moduli are one less than a power of two. For that reason every multiplicative inverse the method needs reduces to a plain bit rotation or a rotation followed by a bitwise complement. The block is meant to sit at the exit of a residue-arithmetic datapath and hand the result to binary logic.

The product M is a little below 2^(4n+1) and above 2^(4n), so the output is 4n+1 bits wide. A parameter selects whether a register stage follows the datapath.

Top module: `rns_rev_conv`

## Requirements
- R1: For every legal triple (in_r0 any 2n-bit value, in_r1 < 2^n−1, in_r2 < 2^(n+1)−1), bin_out equals the unique X in [0, M) with X mod 2^(2n) = in_r0, X mod (2^n−1) = in_r1 and X mod (2^(n+1)−1) = in_r2.
- R2: For legal inputs, bin_out taken modulo 2^n−1 equals in_r1.
- R3: For legal inputs, bin_out taken modulo 2^(n+1)−1 equals in_r2.
- R4: Bits [2n−1:0] of bin_out are an exact copy of in_r0.
- R5: bin_out is 4n+1 bits wide and is always below M = 2^(2n)·(2^n−1)·(2^(n+1)−1).
- R6: With REG_OUT=1, bin_out changes only at a rising clock edge and shows the result for the inputs present at the previous edge. With REG_OUT=0, bin_out follows the inputs combinationally.
- R7: With REG_OUT=1, a low level on rst_n clears bin_out to zero at once, and bin_out stays zero while rst_n is low.
- R8: Both mixed-radix digits are reduced to canonical form, with the all-ones pattern mapped to zero. As a result, when in_r0 ≡ in_r1 (mod 2^n−1), the upper part bin_out >> 2n is an exact multiple of 2^n−1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset of the output register |
| in_r0 | input | 2n | Residue modulo 2^(2n) |
| in_r1 | input | n | Residue modulo 2^n−1 |
| in_r2 | input | n+1 | Residue modulo 2^(n+1)−1 |
| bin_out | output | 4n+1 | Reconstructed binary integer |

## Verification
The assertions check four properties on every clock after reset: the low half of the output copies the first residue, the output reduced by each odd modulus returns the matching residue, the output stays below the dynamic range, and neither internal digit ever holds the all-ones pattern. The bench supplies what these properties cannot. It confirms the exact value by sweeping every legal triple for n=3 and drawing random triples for n=6, checks the one-cycle latency against the value held before the edge, checks clearing by asynchronous reset, and checks the combinational variant.

// File: rtl/rns_rev_pkg.sv
package rns_rev_pkg;
   // output width: the modulus product lies between 2^(4n) and 2^(4n+1)
   function automatic int out_width(input int n);
      return 4 * n + 1;
   endfunction

   // width of the modulo 2^(n+1)-1 channel
   function automatic int wide_width(input int n);
      return n + 1;
   endfunction
endpackage

// File: rtl/rns_rev_csa_eac.sv
// Three-operand carry-save stage for modulus 2^K-1: the carry out of the
// top bit re-enters at bit 0 because 2^K is congruent to 1.
module rns_rev_csa_eac #(
   parameter int K = 4
) (
   input  logic [K-1:0] op_a,
   input  logic [K-1:0] op_b,
   input  logic [K-1:0] op_c,
   output logic [K-1:0] sum_o,
   output logic [K-1:0] car_o
);
   logic [K-1:0] maj;

   always_comb begin
      sum_o = op_a ^ op_b ^ op_c;
      maj   = (op_a & op_b) | (op_a & op_c) | (op_b & op_c);
      car_o = {maj[K-2:0], maj[K-1]};
   end
endmodule

// File: rtl/rns_rev_modadd.sv
// Two-operand adder modulo 2^K-1 with canonical (non all-ones) result.
module rns_rev_modadd #(
   parameter int K = 4
) (
   input  logic [K-1:0] op_a,
   input  logic [K-1:0] op_b,
   output logic [K-1:0] res_o
);
   logic [K:0]   raw;
   logic [K-1:0] folded;

   always_comb begin
      raw    = {1'b0, op_a} + {1'b0, op_b};
      folded = raw[K-1:0] + {{(K-1){1'b0}}, raw[K]};
      res_o  = (&folded) ? '0 : folded;
   end
endmodule

// File: rtl/rns_rev_dig2.sv
// Second mixed-radix digit: (r1 - r0) mod 2^N-1, r0 folded into N-bit halves.
module rns_rev_dig2 #(
   parameter int N = 4
) (
   input  logic [2*N-1:0] r0,
   input  logic [N-1:0]   r1,
   output logic [N-1:0]   dig_o
);
   logic [N-1:0] neg_lo, neg_hi, cs_s, cs_c;

   assign neg_lo = ~r0[N-1:0];
   assign neg_hi = ~r0[2*N-1:N];

   rns_rev_csa_eac #(.K(N)) u_csa (
      .op_a(r1), .op_b(neg_lo), .op_c(neg_hi), .sum_o(cs_s), .car_o(cs_c)
   );

   rns_rev_modadd #(.K(N)) u_add (
      .op_a(cs_s), .op_b(cs_c), .res_o(dig_o)
   );
endmodule

// File: rtl/rns_rev_dig3.sv
// Third mixed-radix digit modulo 2^(N+1)-1:
// v3 = -2 * (4*(r2 - r0) - v2); multiply by 4 = rotate by two,
// multiply by -2 = rotate by one then complement.
module rns_rev_dig3 #(
   parameter int N = 4
) (
   input  logic [2*N-1:0] r0,
   input  logic [N:0]     r2,
   input  logic [N-1:0]   v2,
   output logic [N:0]     dig_o
);
   localparam int K = N + 1;

   logic [K-1:0] r0_lo, r0_hi;
   logic [K-1:0] opd_a, opd_b, opd_c, opd_d;
   logic [K-1:0] s1, c1, s2, c2, e_sum, neg2;

   always_comb begin
      r0_lo = r0[N:0];
      r0_hi = {2'b00, r0[2*N-1:N+1]};
      opd_a = {r2[K-3:0], r2[K-1:K-2]};
      opd_b = ~{r0_lo[K-3:0], r0_lo[K-1:K-2]};
      opd_c = ~{r0_hi[K-3:0], r0_hi[K-1:K-2]};
      opd_d = ~{1'b0, v2};
   end

   rns_rev_csa_eac #(.K(K)) u_csa1 (
      .op_a(opd_a), .op_b(opd_b), .op_c(opd_c), .sum_o(s1), .car_o(c1)
   );

   rns_rev_csa_eac #(.K(K)) u_csa2 (
      .op_a(s1), .op_b(c1), .op_c(opd_d), .sum_o(s2), .car_o(c2)
   );

   rns_rev_modadd #(.K(K)) u_add (
      .op_a(s2), .op_b(c2), .res_o(e_sum)
   );

   always_comb begin
      neg2  = ~{e_sum[K-2:0], e_sum[K-1]};
      dig_o = (&neg2) ? '0 : neg2;
   end
endmodule

// File: rtl/rns_rev_conv.sv
module rns_rev_conv
   import rns_rev_pkg::*;
#(
   parameter int N       = 4,
   parameter bit REG_OUT = 1'b1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [2*N-1:0] in_r0,
   input  logic [N-1:0]   in_r1,
   input  logic [N:0]     in_r2,
   output logic [4*N:0]   bin_out
);
   localparam int WO = out_width(N);
   localparam int WW = wide_width(N);
   localparam int WY = 2 * N + 1;

   if (N < 2) begin : g_bad_n
      $error("rns_rev_conv: N must be at least 2");
   end
   if (WO != 4 * N + 1 || WW != N + 1) begin : g_bad_w
      $error("rns_rev_conv: width derivation mismatch");
   end

   logic [N-1:0]  dig_v2;
   logic [N:0]    dig_v3;
   logic [WY-1:0] upper;
   logic [WO-1:0] full;

   rns_rev_dig2 #(.N(N)) u_dig2 (
      .r0(in_r0), .r1(in_r1), .dig_o(dig_v2)
   );

   rns_rev_dig3 #(.N(N)) u_dig3 (
      .r0(in_r0), .r2(in_r2), .v2(dig_v2), .dig_o(dig_v3)
   );

   // upper = v2 + (2^N - 1) * v3 = {v3, v2} - v3
   always_comb begin
      upper = {dig_v3, dig_v2} - {{N{1'b0}}, dig_v3};
      full  = {upper, in_r0};
   end

   if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) bin_out <= '0;
         else        bin_out <= full;
      end
   end else begin : g_comb
      assign bin_out = full;
   end
endmodule

// File: rtl/rns_rev_conv_chk.sv
module rns_rev_conv_chk #(
   parameter int N       = 4,
   parameter bit REG_OUT = 1'b1
) (
   input logic           clk,
   input logic           rst_n,
   input logic [2*N-1:0] x1,
   input logic [N-1:0]   x2,
   input logic [N:0]     x3,
   input logic [4*N:0]   xo,
   input logic [N-1:0]   v2,
   input logic [N:0]     v3
);
   localparam longint M1 = longint'(1) << (2 * N);
   localparam longint M2 = (longint'(1) << N) - 1;
   localparam longint M3 = (longint'(1) << (N + 1)) - 1;
   localparam longint MT = M1 * M2 * M3;

   logic primed;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) primed <= 1'b0;
      else        primed <= 1'b1;
   end

   // R5
   a_r5_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      64'(xo) < MT);
   // R8
   a_r8_v2_canon: assert property (@(posedge clk) disable iff (!rst_n)
      !(&v2));
   a_r8_v3_canon: assert property (@(posedge clk) disable iff (!rst_n)
      !(&v3));

   if (REG_OUT) begin : g_seq
      a_r4_low_copy: assert property (@(posedge clk) disable iff (!rst_n || !primed)
         xo[2*N-1:0] == $past(x1));
      a_r2_res_m2: assert property (@(posedge clk) disable iff (!rst_n || !primed)
         (64'($past(x2)) < M2) |-> ((64'(xo) % M2) == 64'($past(x2))));
      a_r3_res_m3: assert property (@(posedge clk) disable iff (!rst_n || !primed)
         (64'($past(x3)) < M3) |-> ((64'(xo) % M3) == 64'($past(x3))));
   end else begin : g_cmb
      a_r4_low_copy: assert property (@(posedge clk) disable iff (!rst_n)
         xo[2*N-1:0] == x1);
      a_r2_res_m2: assert property (@(posedge clk) disable iff (!rst_n)
         (64'(x2) < M2) |-> ((64'(xo) % M2) == 64'(x2)));
      a_r3_res_m3: assert property (@(posedge clk) disable iff (!rst_n)
         (64'(x3) < M3) |-> ((64'(xo) % M3) == 64'(x3)));
   end
endmodule

bind rns_rev_conv rns_rev_conv_chk #(.N(N), .REG_OUT(REG_OUT)) u_chk (
   .clk(clk), .rst_n(rst_n), .x1(in_r0), .x2(in_r1), .x3(in_r2),
   .xo(bin_out), .v2(dig_v2), .v3(dig_v3)
);

// File: tb/rns_rev_conv_test.sv
module rns_rev_conv_test;
   localparam int NA = 3;
   localparam int NB = 6;

   logic clk = 1'b0;
   always #2 clk = ~clk;
   logic rst_n;

   logic [2*NA-1:0] a_r0;
   logic [NA-1:0]   a_r1;
   logic [NA:0]     a_r2;
   logic [4*NA:0]   a_out;
   logic [2*NB-1:0] b_r0;
   logic [NB-1:0]   b_r1;
   logic [NB:0]     b_r2;
   logic [4*NB:0]   b_out;

   rns_rev_conv #(.N(NA), .REG_OUT(1'b1)) uut (
      .clk(clk), .rst_n(rst_n), .in_r0(a_r0), .in_r1(a_r1), .in_r2(a_r2), .bin_out(a_out)
   );
   rns_rev_conv #(.N(NB), .REG_OUT(1'b0)) uut_wide (
      .clk(clk), .rst_n(rst_n), .in_r0(b_r0), .in_r1(b_r1), .in_r2(b_r2), .bin_out(b_out)
   );

   int checks = 0;
   int errors = 0;
   longint q_x1[$], q_x2[$], q_x3[$], q_exp[$];

   function automatic longint ref_x(int n, longint x1, longint x2, longint x3);
      longint m1 = longint'(1) << (2 * n);
      longint m2 = (longint'(1) << n) - 1;
      longint m3 = (longint'(1) << (n + 1)) - 1;
      for (longint k = 0; k < m2 * m3; k++) begin
         longint cand = x1 + m1 * k;
         if (cand % m2 == x2 && cand % m3 == x3) return cand;
      end
      return -1;
   endfunction

   task automatic chk(string tag, longint act, longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", tag, act, exp);
      end
   endtask

   // reference comparison on every clock for the registered instance
   always begin
      @(posedge clk);
      #1;
      if (rst_n && q_exp.size() > 0) begin
         longint e  = q_exp.pop_front();
         longint x1 = q_x1.pop_front();
         longint x2 = q_x2.pop_front();
         longint x3 = q_x3.pop_front();
         longint act = longint'(a_out);
         chk("R1 exact value", act, e);
         chk("R4 low copy", act % 64, x1);
         chk("R2 residue mod 7", act % 7, x2);
         chk("R3 residue mod 15", act % 15, x3);
         chk("R5 below range", longint'(act < 6720), 1);
         if (x1 % 7 == x2) chk("R8 canonical second digit", (act >> 6) % 7, 0);
      end
   end

   task automatic drive_a(longint x1, longint x2, longint x3);
      @(negedge clk);
      a_r0 = 6'(x1);
      a_r1 = 3'(x2);
      a_r2 = 4'(x3);
      q_x1.push_back(x1);
      q_x2.push_back(x2);
      q_x3.push_back(x3);
      q_exp.push_back(ref_x(NA, x1, x2, x3));
   endtask

   task automatic drive_b(longint x1, longint x2, longint x3);
      longint e = ref_x(NB, x1, x2, x3);
      b_r0 = 12'(x1);
      b_r1 = 6'(x2);
      b_r2 = 7'(x3);
      #1;
      chk("R6 combinational R1 value", longint'(b_out), e);
      chk("R4 wide low copy", longint'(b_out) % 4096, x1);
   endtask

   initial begin
      #(4 * 150000);
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      rst_n = 1'b0;
      a_r0 = 6'd45; a_r1 = 3'd5; a_r2 = 4'd11;
      b_r0 = '0; b_r1 = '0; b_r2 = '0;
      repeat (3) @(posedge clk);
      #1;
      chk("R7 output zero in reset", longint'(a_out), 0);
      @(negedge clk);
      rst_n = 1'b1;

      // exhaustive sweep, n=3
      for (int i = 0; i < 64; i++)
         for (int j = 0; j < 7; j++)
            for (int k = 0; k < 15; k++)
               drive_a(i, j, k);
      repeat (3) @(negedge clk);

      // latency: the new inputs must not show before the edge
      drive_a(1, 2, 3);
      @(posedge clk);
      drive_a(62, 0, 14);
      #1;
      chk("R6 output held until edge", longint'(a_out), ref_x(NA, 1, 2, 3));
      repeat (3) @(negedge clk);

      // asynchronous reset clears at once
      #1;
      rst_n = 1'b0;
      #0.5;
      chk("R7 asynchronous clear", longint'(a_out), 0);
      @(posedge clk);
      #1;
      chk("R7 stays zero in reset", longint'(a_out), 0);
      @(negedge clk);
      rst_n = 1'b1;

      // combinational wide instance, n=6
      drive_b(0, 0, 0);
      drive_b(4095, 62, 126);
      drive_b(4095, 0, 0);
      drive_b(0, 62, 126);
      for (int t = 0; t < 300; t++)
         drive_b(longint'($urandom % 4096), longint'($urandom % 63), longint'($urandom % 127));

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule